// File: doc/BRIEF.md
# SDRAM Special-Mode Command Generator

This block sits between a CPU-side access port and the command and address pins of an SDRAM. A control register holds an enable bit and a mode field. While the block is enabled and the mode is one of the special modes, each CPU read or write that falls into one of the two chip-select windows becomes one SDRAM command cycle:

- precharge, or
- auto-refresh, or
- load mode register.

In normal mode the block issues a placeholder row-activate command that stands in for a real data transfer.

In every mode the CPU address is copied onto the memory address pins bit for bit, with no shift for the memory width. Firmware can therefore reach a given memory pin through the matching CPU address bit. For example, it sets address bit 10 to precharge all banks. In load-mode-register mode it places the mode register value in the low offset bits.

The CPU holds its request until the block returns a one-cycle acknowledge. An access that issues no command is acknowledged on the cycle after it is accepted. This happens when the access misses both windows, when the block is disabled, or when the mode value is reserved.

Top module: `sdram_special_cmd_gen`

## Requirements
- R1: After reset the control register is disabled with mode 0, `bus_ack` is low and the pins drive the idle command.
- R2: A write on `cfg_we` loads the control register. Bit 31 of `cfg_wdata` is the enable and bits 30:28 are the mode: 0 normal, 1 precharge, 2 auto-refresh, 3 load mode register, 4 to 7 reserved. The register holds its value when `cfg_we` is low.
- R3: While the enable bit is clear, an access issues no command and is acknowledged in the cycle after it is accepted.
- R4: In precharge mode each in-window access drives exactly one command cycle with {RAS#,CAS#,WE#} = 010.
- R5: In auto-refresh mode each in-window access drives one command cycle with {RAS#,CAS#,WE#} = 001.
- R6: In load-mode-register mode each in-window access drives one command cycle with {RAS#,CAS#,WE#} = 000, and `mem_addr` equals the low address bits. For example, offset 0x33 gives 0x033.
- R7: During a command, `mem_addr[i]` equals `bus_addr[i]` for every i below MA_W, and `mem_ba` equals `bus_addr[MA_W+BA_W-1:MA_W]`. With the default MA_W=13, offsets 0xF00 and 0x400 both set `mem_addr[10]`, which selects precharge all.
- R8: Addresses 0x8xxxxxxx pull `mem_cs_n[0]` low during their command, and addresses 0x9xxxxxxx pull `mem_cs_n[1]` low. The other chip select stays high.
- R9: An access whose top nibble is neither 0x8 nor 0x9 issues no command and is acknowledged in the cycle after it is accepted.
- R10: `bus_ack` is high for exactly one cycle, and that cycle directly follows the command cycle.
- R11: In normal mode each in-window access drives one placeholder activate command with {RAS#,CAS#,WE#} = 011.
- R12: With a reserved mode (4 to 7), an access issues no command and is acknowledged in the cycle after it is accepted.
- R13: When no command is being issued, the pins drive NOP: both chip selects low and {RAS#,CAS#,WE#} = 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control word |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_addr | input | 32 | CPU byte address of the access |
| bus_ack | output | 1 | One-cycle access acknowledge |
| mem_cs_n | output | NUM_CS | Chip selects, active low |
| mem_ras_n | output | 1 | Row address strobe, active low |
| mem_cas_n | output | 1 | Column address strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_addr | output | MA_W | Memory address pins |
| mem_ba | output | BA_W | Memory bank address pins |

## Verification
The bench runs precharge at offsets 0xF00, 0x400 and 0x000, and a design that shifted the address by the memory width would move or drop A10. An offset above the row/column field checks the bank pins, which an off-by-one slice would corrupt. Accesses in the second window, outside both windows, with the enable clear, and with a reserved mode check the other paths. A design that decoded only the mode field, ignored the window, or put commands on the wrong chip would emit a stray command or drive the wrong select. Every acknowledge is timed against its request, which catches an acknowledge that is late, repeated, or coincides with the command.

// File: rtl/sdcmd_pkg.sv
// Shared constants for the SDRAM special-mode command generator.
// Assumes command encodings on {RAS#,CAS#,WE#}; chip select is driven separately.
package sdcmd_pkg;
    localparam logic [2:0] MODE_NORMAL    = 3'd0;
    localparam logic [2:0] MODE_PRECHARGE = 3'd1;
    localparam logic [2:0] MODE_REFRESH   = 3'd2;
    localparam logic [2:0] MODE_LOADMODE  = 3'd3;

    localparam logic [2:0] CMD_NOP       = 3'b111;
    localparam logic [2:0] CMD_ACTIVATE  = 3'b011;
    localparam logic [2:0] CMD_PRECHARGE = 3'b010;
    localparam logic [2:0] CMD_REFRESH   = 3'b001;
    localparam logic [2:0] CMD_LOADMODE  = 3'b000;
endpackage

// File: rtl/sdcmd_ctrl_reg.sv
// Control register: holds the enable bit and the 3-bit mode field.
// Assumes the caller passes the top nibble of the control word {enable, mode}.
module sdcmd_ctrl_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [3:0] wr_nibble,
    output logic       enable,
    output logic [2:0] mode
);
    // Load enable and mode on a write; reset to disabled normal mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= 1'b0;
            mode   <= 3'd0;
        end else if (wr_en) begin
            enable <= wr_nibble[3];
            mode   <= wr_nibble[2:0];
        end
    end

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(mode) && $stable(enable))); // R2
endmodule

// File: rtl/sdcmd_cs_decode.sv
// Chip-select window decoder: window i matches top address bits == BASE + i.
// Assumes windows are consecutive and therefore disjoint.
module sdcmd_cs_decode #(
    parameter int                  NUM_CS   = 2,
    parameter int                  WIN_BITS = 4,
    parameter logic [WIN_BITS-1:0] BASE     = 4'h8
) (
    input  logic [WIN_BITS-1:0] addr_top,
    output logic [NUM_CS-1:0]   hit_vec
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_win
        localparam logic [WIN_BITS-1:0] WinBase = WIN_BITS'(BASE + i);
        // Compare the top address bits against this window's base.
        assign hit_vec[i] = (addr_top == WinBase);
    end
endmodule

// File: rtl/sdcmd_seq.sv
// Access sequencer: turns one accepted access into at most one command cycle,
// then one acknowledge cycle. Addresses are passed to the pins without shifting.
// Assumes the requester holds req until ack and drops it in the ack cycle.
module sdcmd_seq
    import sdcmd_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int MA_W   = 13,
    parameter int BA_W   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req,
    input  logic [MA_W+BA_W-1:0] addr,
    input  logic [NUM_CS-1:0]    hit_vec,
    input  logic                 enable,
    input  logic [2:0]           mode,
    output logic [NUM_CS-1:0]    cs_n,
    output logic [2:0]           cmd,
    output logic [MA_W-1:0]      ma,
    output logic [BA_W-1:0]      ba,
    output logic                 ack
);
    typedef enum logic [1:0] {ST_IDLE, ST_CMD, ST_ACK} state_e;
    state_e     state;
    logic [2:0] cmd_sel;
    logic       issue;

    // Pick the command for the current mode; reserved modes issue nothing.
    always_comb begin
        cmd_sel = CMD_NOP;
        case (mode)
            MODE_NORMAL:    cmd_sel = CMD_ACTIVATE;
            MODE_PRECHARGE: cmd_sel = CMD_PRECHARGE;
            MODE_REFRESH:   cmd_sel = CMD_REFRESH;
            MODE_LOADMODE:  cmd_sel = CMD_LOADMODE;
            default:        cmd_sel = CMD_NOP;
        endcase
        issue = enable && (cmd_sel != CMD_NOP) && (|hit_vec);
    end

    // Accept, issue one command, acknowledge, return to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cs_n  <= '0;
            cmd   <= CMD_NOP;
            ma    <= '0;
            ba    <= '0;
            ack   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    ack <= 1'b0;
                    if (req) begin
                        if (issue) begin
                            state <= ST_CMD;
                            cs_n  <= ~hit_vec;
                            cmd   <= cmd_sel;
                            ma    <= addr[MA_W-1:0];
                            ba    <= addr[MA_W +: BA_W];
                        end else begin
                            state <= ST_ACK;
                            ack   <= 1'b1;
                        end
                    end
                end
                ST_CMD: begin
                    state <= ST_ACK;
                    cs_n  <= '0;
                    cmd   <= CMD_NOP;
                    ack   <= 1'b1;
                end
                default: begin
                    state <= ST_IDLE;
                    ack   <= 1'b0;
                end
            endcase
        end
    end

    AST_CMD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |=> (cmd == CMD_NOP)); // R4
    AST_ACK_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |=> ack); // R10
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack); // R10
    AST_CMD_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_NOP) |-> ($countones(cs_n) == NUM_CS - 1)); // R8
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && req && !enable) |=> (cmd == CMD_NOP && ack)); // R3
endmodule

// File: rtl/sdram_special_cmd_gen.sv
// Top: SDRAM special-mode command generator. Decodes the control register,
// the chip-select windows and drives one command per accepted access.
// Assumes MA_W + BA_W stays below the window field (bit 28).
module sdram_special_cmd_gen
    import sdcmd_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int MA_W   = 13,
    parameter int BA_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    input  logic              bus_req,
    input  logic [31:0]       bus_addr,
    output logic              bus_ack,
    output logic [NUM_CS-1:0] mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [MA_W-1:0]   mem_addr,
    output logic [BA_W-1:0]   mem_ba
);
    localparam int MapW = MA_W + BA_W;

    logic              enable;
    logic [2:0]        mode;
    logic [NUM_CS-1:0] hit_vec;
    logic [2:0]        cmd;
    logic              unused_bits;

    assign unused_bits = ^{cfg_wdata, bus_addr};

    sdcmd_ctrl_reg u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_nibble (cfg_wdata[31:28]),
        .enable    (enable),
        .mode      (mode)
    );

    sdcmd_cs_decode #(.NUM_CS(NUM_CS), .WIN_BITS(4), .BASE(4'h8)) u_dec (
        .addr_top (bus_addr[31:28]),
        .hit_vec  (hit_vec)
    );

    sdcmd_seq #(.NUM_CS(NUM_CS), .MA_W(MA_W), .BA_W(BA_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (bus_req),
        .addr    (bus_addr[MapW-1:0]),
        .hit_vec (hit_vec),
        .enable  (enable),
        .mode    (mode),
        .cs_n    (mem_cs_n),
        .cmd     (cmd),
        .ma      (mem_addr),
        .ba      (mem_ba),
        .ack     (bus_ack)
    );

    // Split the command triple onto the strobe pins.
    assign {mem_ras_n, mem_cas_n, mem_we_n} = cmd;

    AST_ADDR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && cmd == CMD_NOP && $past(cmd) == CMD_NOP && $past(!bus_ack))
        |=> ((cmd == CMD_NOP) || (mem_addr == $past(bus_addr[MA_W-1:0])))); // R7
endmodule

// File: tb/sim_sdram_special_cmd_gen.sv
module sim_sdram_special_cmd_gen;
    localparam int NUM_CS = 2;
    localparam int MA_W   = 13;
    localparam int BA_W   = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [31:0]       cfg_wdata = '0;
    logic              bus_req = 1'b0;
    logic [31:0]       bus_addr = '0;
    logic              bus_ack;
    logic [NUM_CS-1:0] mem_cs_n;
    logic              mem_ras_n, mem_cas_n, mem_we_n;
    logic [MA_W-1:0]   mem_addr;
    logic [BA_W-1:0]   mem_ba;

    sdram_special_cmd_gen #(.NUM_CS(NUM_CS), .MA_W(MA_W), .BA_W(BA_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_ack(bus_ack),
        .mem_cs_n(mem_cs_n), .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n),
        .mem_we_n(mem_we_n), .mem_addr(mem_addr), .mem_ba(mem_ba)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic            hit;
        logic [2:0]      cmd;
        logic [1:0]      cs_n;
        logic [MA_W-1:0] ma;
        logic [BA_W-1:0] ba;
        int              ack_cyc;
        string           tag;
    } item_t;

    item_t      exp_q[$];
    int         tests = 0;
    int         fails = 0;
    int         cyc = 0;
    logic       m_en = 1'b0;
    logic [2:0] m_mode = 3'd0;
    logic       done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input logic ok, input string tag, input string act, input string exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %s expected %s", tag, act, exp);
        end
    endtask

    task automatic wr_cfg(input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = w;
        m_en = w[31];           // R2: enable at bit 31
        m_mode = w[30:28];      // R2: mode at bits 30:28
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic [31:0] a, input string tag);
        item_t it;
        logic  win;
        @(negedge clk);
        win = (a[31:28] == 4'h8) || (a[31:28] == 4'h9);
        it.hit = m_en && (m_mode <= 3'd3) && win;
        case (m_mode)
            3'd0:    it.cmd = 3'b011;
            3'd1:    it.cmd = 3'b010;
            3'd2:    it.cmd = 3'b001;
            default: it.cmd = 3'b000;
        endcase
        it.cs_n = (a[31:28] == 4'h8) ? 2'b10 : 2'b01;
        it.ma = a[MA_W-1:0];
        it.ba = a[MA_W +: BA_W];
        it.ack_cyc = it.hit ? cyc + 2 : cyc + 1;
        it.tag = tag;
        exp_q.push_back(it);
        bus_req = 1'b1;
        bus_addr = a;
        do @(negedge clk); while (!bus_ack);
        bus_req = 1'b0;
        @(negedge clk);
    endtask

    // Monitor: collect command cycles, compare against the scoreboard on each ack.
    int         n_cmd = 0;
    int         last_cyc = 0;
    logic [2:0] l_cmd;
    logic [1:0] l_cs;
    logic [MA_W-1:0] l_ma;
    logic [BA_W-1:0] l_ba;
    always @(negedge clk) begin
        if (rst_n) begin
            if ({mem_ras_n, mem_cas_n, mem_we_n} != 3'b111) begin
                n_cmd++;
                last_cyc = cyc;
                l_cmd = {mem_ras_n, mem_cas_n, mem_we_n};
                l_cs = mem_cs_n;
                l_ma = mem_addr;
                l_ba = mem_ba;
            end
            if (bus_ack) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected ack", "ack", "none");
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    if (e.hit)
                        check(n_cmd == 1 && last_cyc == cyc - 1 && cyc == e.ack_cyc &&
                              l_cmd == e.cmd && l_cs == e.cs_n && l_ma == e.ma && l_ba == e.ba,
                              e.tag,
                              $sformatf("n=%0d cmd=%b cs=%b ma=%h ba=%h ackcyc=%0d", n_cmd, l_cmd, l_cs, l_ma, l_ba, cyc),
                              $sformatf("n=1 cmd=%b cs=%b ma=%h ba=%h ackcyc=%0d", e.cmd, e.cs_n, e.ma, e.ba, e.ack_cyc));
                    else
                        check(n_cmd == 0 && cyc == e.ack_cyc, e.tag,
                              $sformatf("n=%0d ackcyc=%0d", n_cmd, cyc),
                              $sformatf("n=0 ackcyc=%0d", e.ack_cyc));
                end
                n_cmd = 0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(bus_ack == 1'b0 && mem_cs_n == 2'b00 && {mem_ras_n, mem_cas_n, mem_we_n} == 3'b111,
              "R1 reset idle", $sformatf("ack=%b cs=%b cmd=%b", bus_ack, mem_cs_n, {mem_ras_n, mem_cas_n, mem_we_n}),
              "ack=0 cs=00 cmd=111");
        access(32'h8000_0400, "R3 disabled after reset");
        wr_cfg(32'h9210_0000);
        access(32'h8000_0F00, "R4 R7 precharge all 0xF00");
        access(32'h8000_0400, "R4 R7 precharge all 0x400");
        access(32'h8000_0000, "R4 precharge single bank");
        access(32'h9000_0400, "R8 second window");
        access(32'h8000_6400, "R7 bank bits");
        access(32'hA000_0000, "R9 outside windows high");
        access(32'h7FFF_FFFC, "R9 outside windows low");
        wr_cfg(32'hA210_0000);
        access(32'h8000_0000, "R5 auto refresh");
        access(32'h9000_0010, "R5 R8 refresh second window");
        wr_cfg(32'hB210_0000);
        access(32'h8000_0033, "R6 load mode 0x33");
        wr_cfg(32'h8210_0000);
        access(32'h8000_1234, "R11 normal stub");
        wr_cfg(32'hC210_0000);
        access(32'h8000_0400, "R12 reserved mode 4");
        wr_cfg(32'hF210_0000);
        access(32'h9000_0400, "R12 reserved mode 7");
        wr_cfg(32'h3210_0000);
        access(32'h8000_0033, "R3 enable clear mode 3");
        wr_cfg(32'h9210_0000);
        access(32'h9000_0F00, "R2 re-enable precharge");
        repeat (3) @(negedge clk);
        check(bus_ack == 1'b0 && mem_cs_n == 2'b00 && {mem_ras_n, mem_cas_n, mem_we_n} == 3'b111,
              "R13 idle NOP", $sformatf("ack=%b cs=%b cmd=%b", bus_ack, mem_cs_n, {mem_ras_n, mem_cas_n, mem_we_n}),
              "ack=0 cs=00 cmd=111");
        check(exp_q.size() == 0, "R10 all accesses acknowledged",
              $sformatf("%0d pending", exp_q.size()), "0 pending");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule